// File: doc/BRIEF.md
# Registered 8-bit Arithmetic-Logic Unit

This block is a small synchronous arithmetic-logic stage. On every rising clock edge it captures two 8-bit operands and a 4-bit operation code. On the next edge it registers an 8-bit result and a carry-out. A new operation can be issued on every clock, so each result appears two edges after its operands were presented.

All arithmetic operations go through one carry-lookahead adder. The adder forms a generate and a propagate term for each bit and computes every carry directly from those terms and the carry-in, with no ripple chain. Increment, add-with-carry, add-of-complement and the two pass-through operations reuse this adder. They do so by choosing what enters each adder input (the operand, its complement or zero) and by setting the carry-in. The bitwise logic operations are formed next to the adder, and a final selector picks the value that is registered.

Top module: `regAlu`

## Requirements
- R1: A synchronous active-high reset clears the operand registers, the opcode register, `yOut` and `carryOut` to zero. In the first cycle after reset, the result is computed from those cleared registers and not from the pins.
- R2: Operands and opcode present at clock edge k produce their result on `yOut`/`carryOut` after edge k+1. A different operation can be accepted on every edge.
- R3: Opcode 4'b0000 gives `yOut` = (A+B) mod 256 and `carryOut` = bit 8 of A+B.
- R4: Opcode 4'b0001 gives `yOut` = (A+B+1) mod 256 and `carryOut` = bit 8 of A+B+1.
- R5: Opcode 4'b0010 gives `yOut` = (A+~B) mod 256 and `carryOut` = bit 8 of A+(255−B).
- R6: Opcode 4'b0011 gives `yOut` = A, and opcode 4'b0100 gives `yOut` = B. Both give `carryOut` = 0.
- R7: Opcode 4'b0101 gives `yOut` = (A+1) mod 256 and `carryOut` = 1 exactly when A = 8'hFF.
- R8: Opcodes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 give A XOR B, A AND B, A OR B and ~A respectively, each with `carryOut` = 0.
- R9: Opcodes 4'b0110, 4'b0111 and 4'b1100 through 4'b1111 give `yOut` = 0 and `carryOut` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| aIn | input | 8 | First operand |
| bIn | input | 8 | Second operand |
| opSel | input | 4 | Operation code |
| yOut | output | 8 | Registered result |
| carryOut | output | 1 | Registered carry-out |

## Verification
The hardest case to observe from the ports is the reset clearing the operand and opcode registers. A cleared pipeline and an add of zero plus zero both show an all-zero output. To separate the two, the bench holds all-ones operands with the add-plus-one code during reset and then switches to an unused code. Only cleared input registers leave zero on the output one edge later; stale registers would show 8'hFF with a carry. The longest carry path, which is a carry generated at bit 0 that propagates through all eight bits, is reached by sweeping every A value against B values that include 8'h01 and 8'hFF under each opcode.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [3:0] {
    OP_ADD      = 4'b0000,
    OP_ADD_INC  = 4'b0001,
    OP_ADD_NOTB = 4'b0010,
    OP_PASS_A   = 4'b0011,
    OP_PASS_B   = 4'b0100,
    OP_INC_A    = 4'b0101,
    OP_XOR      = 4'b1000,
    OP_AND      = 4'b1001,
    OP_OR       = 4'b1010,
    OP_NOT_A    = 4'b1011
  } opCode_e;

  // what the second adder input carries
  typedef enum logic [1:0] {
    B_PLAIN  = 2'd0,
    B_INVERT = 2'd1,
    B_ZERO   = 2'd2
  } bSel_e;

  // which value goes into the result register
  typedef enum logic [2:0] {
    RES_SUM  = 3'd0,
    RES_XOR  = 3'd1,
    RES_AND  = 3'd2,
    RES_OR   = 3'd3,
    RES_NOTA = 3'd4,
    RES_ZERO = 3'd5
  } resSel_e;

  typedef struct packed {
    logic    zeroA;
    bSel_e   bSel;
    logic    carryIn;
    logic    keepCarry;
    resSel_e resSel;
  } aluStrobes_t;

endpackage

// File: rtl/claAdder.sv
module claAdder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH:0]   carry;

  assign gen  = a & b;
  assign prop = a ^ b;

  // Carry into bit top+1, flattened into a sum of products over gen/prop/cin
  function automatic logic lookCarry(
    input logic [WIDTH-1:0] g,
    input logic [WIDTH-1:0] p,
    input logic             c0,
    input int               top
  );
    logic acc;
    logic chain;
    acc   = 1'b0;
    chain = 1'b1;
    for (int j = top; j >= 0; j--) begin
      acc   = acc | (chain & g[j]);
      chain = chain & p[j];
    end
    return acc | (chain & c0);
  endfunction

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_carry
    assign carry[i+1] = lookCarry(gen, prop, cin, i);
  end

  assign sum  = prop ^ carry[WIDTH-1:0];
  assign cout = carry[WIDTH];

endmodule

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
#(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opSel,
  output aluStrobes_t    strobes
);

  logic [OPW-1:0] opReg;

  always_ff @(posedge clk) begin
    if (rst) opReg <= '0;
    else     opReg <= opSel;
  end

  always_comb begin
    strobes.zeroA     = 1'b0;
    strobes.bSel      = B_ZERO;
    strobes.carryIn   = 1'b0;
    strobes.keepCarry = 1'b0;
    strobes.resSel    = RES_ZERO;
    case (opReg)
      OP_ADD: begin
        strobes.bSel      = B_PLAIN;
        strobes.keepCarry = 1'b1;
        strobes.resSel    = RES_SUM;
      end
      OP_ADD_INC: begin
        strobes.bSel      = B_PLAIN;
        strobes.carryIn   = 1'b1;
        strobes.keepCarry = 1'b1;
        strobes.resSel    = RES_SUM;
      end
      OP_ADD_NOTB: begin
        strobes.bSel      = B_INVERT;
        strobes.keepCarry = 1'b1;
        strobes.resSel    = RES_SUM;
      end
      OP_PASS_A: begin
        strobes.bSel   = B_ZERO;
        strobes.resSel = RES_SUM;
      end
      OP_PASS_B: begin
        strobes.zeroA  = 1'b1;
        strobes.bSel   = B_PLAIN;
        strobes.resSel = RES_SUM;
      end
      OP_INC_A: begin
        strobes.bSel      = B_ZERO;
        strobes.carryIn   = 1'b1;
        strobes.keepCarry = 1'b1;
        strobes.resSel    = RES_SUM;
      end
      OP_XOR:   strobes.resSel = RES_XOR;
      OP_AND:   strobes.resSel = RES_AND;
      OP_OR:    strobes.resSel = RES_OR;
      OP_NOT_A: strobes.resSel = RES_NOTA;
      default:  strobes.resSel = RES_ZERO;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] yOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] aReg, bReg;
  logic [WIDTH-1:0] addA, addB, addSum;
  logic             addCout;
  logic [WIDTH-1:0] nextY;

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg <= '0;
      bReg <= '0;
    end else begin
      aReg <= aIn;
      bReg <= bIn;
    end
  end

  assign addA = strobes.zeroA ? '0 : aReg;

  always_comb begin
    case (strobes.bSel)
      B_PLAIN:  addB = bReg;
      B_INVERT: addB = ~bReg;
      default:  addB = '0;
    endcase
  end

  claAdder #(.WIDTH(WIDTH)) i_claAdder (
    .a   (addA),
    .b   (addB),
    .cin (strobes.carryIn),
    .sum (addSum),
    .cout(addCout)
  );

  always_comb begin
    case (strobes.resSel)
      RES_SUM:  nextY = addSum;
      RES_XOR:  nextY = aReg ^ bReg;
      RES_AND:  nextY = aReg & bReg;
      RES_OR:   nextY = aReg | bReg;
      RES_NOTA: nextY = ~aReg;
      default:  nextY = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      yOut     <= '0;
      carryOut <= 1'b0;
    end else begin
      yOut     <= nextY;
      carryOut <= strobes.keepCarry & addCout;
    end
  end

endmodule

// File: rtl/regAlu.sv
module regAlu
  import aluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic [3:0]       opSel,
  output logic [WIDTH-1:0] yOut,
  output logic             carryOut
);

  aluStrobes_t strobes;

  aluCtrl #(.OPW(4)) i_aluCtrl (
    .clk    (clk),
    .rst    (rst),
    .opSel  (opSel),
    .strobes(strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) i_aluDatapath (
    .clk     (clk),
    .rst     (rst),
    .aIn     (aIn),
    .bIn     (bIn),
    .strobes (strobes),
    .yOut    (yOut),
    .carryOut(carryOut)
  );

endmodule

// File: rtl/regAluChk.sv
module regAluChk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] yOut,
  input logic             carryOut
);

  logic [WIDTH-1:0] aQ1, aQ2, bQ1, bQ2;
  logic [3:0]       opQ1, opQ2;
  logic [1:0]       histCnt;
  logic             histOk;

  always_ff @(posedge clk) begin
    aQ1 <= aIn;  aQ2 <= aQ1;
    bQ1 <= bIn;  bQ2 <= bQ1;
    opQ1 <= opSel; opQ2 <= opQ1;
    if (rst)                histCnt <= 2'd0;
    else if (histCnt != 2'd2) histCnt <= histCnt + 2'd1;
  end

  assign histOk = (histCnt == 2'd2);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (yOut == '0 && !carryOut));

  // R3
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (histOk && opQ2 == 4'b0000) |-> ({carryOut, yOut} == ({1'b0, aQ2} + {1'b0, bQ2})));

  // R5
  add_notb_chk: assert property (@(posedge clk) disable iff (rst)
    (histOk && opQ2 == 4'b0010) |-> ({carryOut, yOut} == ({1'b0, aQ2} + {1'b0, ~bQ2})));

  // R6
  pass_a_chk: assert property (@(posedge clk) disable iff (rst)
    (histOk && opQ2 == 4'b0011) |-> (yOut == aQ2 && !carryOut));

  // R6
  pass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (histOk && opQ2 == 4'b0100) |-> (yOut == bQ2 && !carryOut));

  // R8
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (histOk && opQ2[3:2] == 2'b10) |-> !carryOut);

  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (histOk && (opQ2 == 4'b0110 || opQ2 == 4'b0111 || opQ2[3:2] == 2'b11))
      |-> (yOut == '0 && !carryOut));

endmodule

bind regAlu regAluChk #(.WIDTH(WIDTH)) u_regAluChk (
  .clk     (clk),
  .rst     (rst),
  .aIn     (aIn),
  .bIn     (bIn),
  .opSel   (opSel),
  .yOut    (yOut),
  .carryOut(carryOut)
);

// File: tb/test_regAlu.sv
`timescale 1ns/1ps
module test_regAlu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] aIn = '0;
  logic [7:0] bIn = '0;
  logic [3:0] opSel = '0;
  logic [7:0] yOut;
  logic       carryOut;

  int checks = 0;
  int fails  = 0;

  // two-deep queue of outstanding expectations
  bit         qv [2];
  logic [8:0] qe [2];
  logic [3:0] qop[2];

  logic [7:0] bList [12] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h55,
                             8'h7F, 8'h80, 8'hAA, 8'hF0, 8'hFE, 8'hFF};

  always #4 clk = ~clk;

  regAlu #(.WIDTH(8)) i_regAlu (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn), .opSel(opSel),
    .yOut(yOut), .carryOut(carryOut)
  );

  function automatic logic [8:0] refCalc(input logic [7:0] a, input logic [7:0] b,
                                         input logic [3:0] op);
    case (op)
      4'b0000: return {1'b0, a} + {1'b0, b};
      4'b0001: return {1'b0, a} + {1'b0, b} + 9'd1;
      4'b0010: return {1'b0, a} + {1'b0, ~b};
      4'b0011: return {1'b0, a};
      4'b0100: return {1'b0, b};
      4'b0101: return {1'b0, a} + 9'd1;
      4'b1000: return {1'b0, a ^ b};
      4'b1001: return {1'b0, a & b};
      4'b1010: return {1'b0, a | b};
      4'b1011: return {1'b0, ~a};
      default: return 9'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'b0000: return "R3";
      4'b0001: return "R4";
      4'b0010: return "R5";
      4'b0011, 4'b0100: return "R6";
      4'b0101: return "R7";
      4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOut(input string tag, input logic [8:0] exp);
    checks++;
    if ({carryOut, yOut} !== exp) begin
      fails++;
      $display("FAIL %s: y=%h cout=%b expected y=%h cout=%b",
               tag, yOut, carryOut, exp[7:0], exp[8]);
    end
  endtask

  // drive one operation at a falling edge; check the one issued two steps earlier (R2)
  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
    @(negedge clk);
    if (qv[1]) checkOut({tagOf(qop[1]), " (R2 stream)"}, qe[1]);
    qv[1] = qv[0]; qe[1] = qe[0]; qop[1] = qop[0];
    qv[0] = 1'b1;  qe[0] = refCalc(a, b, op); qop[0] = op;
    aIn = a; bIn = b; opSel = op;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    qv[0] = 1'b0; qv[1] = 1'b0;
    // R1: reset state
    repeat (3) @(negedge clk);
    checkOut("R1 reset state", 9'd0);
    rst = 1'b0;

    // R2: result appears after the second edge, not the first
    @(negedge clk);
    aIn = 8'h21; bIn = 8'h12; opSel = 4'b0000;
    @(negedge clk);
    checkOut("R2 not before second edge", 9'd0);
    opSel = 4'b1111; aIn = '0; bIn = '0;
    @(negedge clk);
    checkOut("R2 after second edge", 9'h033);
    @(negedge clk);
    checkOut("R9 follow-up unused code", 9'd0);

    // R7 corner cases issued back to back
    step(8'hFF, 8'h00, 4'b0101);
    step(8'hFE, 8'h00, 4'b0101);
    // R3 corners: FF+01, 00+00, FF+FF
    step(8'hFF, 8'h01, 4'b0000);
    step(8'h00, 8'h00, 4'b0000);
    step(8'hFF, 8'hFF, 4'b0000);

    // near-exhaustive sweep: every opcode, every A, twelve B values
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 12; k++)
          step(8'(a), bList[k], 4'(op));
    step(8'h00, 8'h00, 4'b1111);
    step(8'h00, 8'h00, 4'b1111);
    step(8'h00, 8'h00, 4'b1111);

    // R1: reset mid-stream clears the input registers too
    @(negedge clk);
    rst = 1'b1; aIn = 8'hFF; bIn = 8'hFF; opSel = 4'b0001;
    qv[0] = 1'b0; qv[1] = 1'b0;
    @(negedge clk);
    checkOut("R1 output cleared in reset", 9'd0);
    rst = 1'b0; opSel = 4'b1111;
    @(negedge clk);
    checkOut("R1 input registers cleared", 9'd0);
    @(negedge clk);
    checkOut("R9 after reset release", 9'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule